// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks the chain of extended capability headers that lives in the upper part of a 4 KB configuration space. A caller pulses `start_i` with an operation code and, for a lookup, a 16-bit capability identifier. The walker then fetches 32-bit headers through a synchronous read port, beginning at byte offset 0x100 and following each header's link field. It reports the offset of the first header whose identifier matches, or 0 when nothing matches. It also reports the offset of the header visited just before the stopping point.

A second lookup mode never matches. Its only purpose is to find the last header in the chain. The append operation uses it. Append writes a fresh header at a caller-chosen offset. When that offset is not the chain's base, the walker first points the old tail at the new header. Broken links and chains that loop are reported through an error flag. The walk does not run forever.

Top module: `ecap_chain_walker`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `result_o` and `prev_o` are all 0, and no memory read or write is issued until `start_i` is seen.
- R2: A start is accepted only while idle. A start while busy has no effect on the running operation or on its results. `busy_o` is high for exactly two cycles per header read plus one cycle per memory write. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. Results stay unchanged until the next accepted start. `op_i` codes are: 0 = lookup, 1 = find tail, 2 = append, 3 = find tail.
- R3: If the 32-bit word at offset 0x100 is zero, the chain is empty. A lookup or find-tail then ends after one read with result 0, previous 0 and no error.
- R4: A header holds the identifier in bits 15:0, a version in bits 19:16 and the next-header byte offset in bits 31:20. Read data is taken one cycle after the read address. Every read address is 4-byte aligned and lies in 0x100..0xFF8. Reads and writes never occur in the same cycle.
- R5: A lookup stops at the first header whose bits 15:0 equal `cap_id_i`. It returns that header's offset as the result and the offset of the header read before it as previous (0 when the match is the first header).
- R6: A lookup that reaches a header with next offset 0 without a match returns result 0 and previous equal to that last header's offset.
- R7: Find-tail (codes 1 and 3) never matches, even when a header carries the same identifier as `cap_id_i`. It returns result 0 and previous equal to the last header's offset.
- R8: A nonzero next offset that is not 4-byte aligned, below 0x100 or above 0xFF8 ends the walk with `err_o` = 1, result 0, and previous equal to the offset of the header holding the bad link.
- R9: After STEP_LIMIT (default 1024) header reads without reaching a match or an end, the walk stops with `err_o` = 1, result 0, and previous equal to the last header read.
- R10: Append at offset 0x100 issues no read. It makes exactly one write of {next = 0, `cap_ver_i`, `cap_id_i`} at 0x100 and returns result 0x100 with previous 0.
- R11: Append at any other offset first walks to the tail. It then rewrites the tail header with only bits 31:20 changed to the new offset, and after that writes {next = 0, `cap_ver_i`, `cap_id_i`} at the new offset. It returns result = new offset and previous = tail offset.
- R12: An append is rejected with `err_o` = 1, result 0, previous 0, no read, no write and zero busy cycles in any of these cases: the offset is below 0x100, the offset is not 4-byte aligned, offset + `size_i` is above 4096, or `size_i` is below 8. An append at a non-base offset onto an empty chain is rejected with `err_o` = 1 and no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 2 | Operation code (see R2) |
| cap_id_i | input | 16 | Identifier to find, or to write on append |
| cap_ver_i | input | 4 | Version written on append |
| offset_i | input | 12 | Byte offset of the appended header |
| size_i | input | 13 | Size in bytes of the appended region |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error status of the last operation |
| result_o | output | 12 | Matching or appended offset, else 0 |
| prev_o | output | 12 | Offset of the preceding or tail header |
| mem_rd_en_o | output | 1 | Read request |
| mem_wr_en_o | output | 1 | Write request |
| mem_addr_o | output | 12 | Byte address for read or write |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |

## Verification
The iteration guard is the hardest case to reach from the ports, because a well-formed chain always ends long before 1024 steps. The bench writes a header at 0x100 whose link points back to itself, then issues a lookup for an absent identifier. The walk can then only stop through the guard, after exactly 2048 busy cycles. Bad links are reached the same way, by writing malformed next fields straight into the bench memory behind the walker's back.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;

    localparam int OFF_W     = 12;
    localparam int HDR_W     = 32;
    localparam int ID_W      = 16;
    localparam int VER_W     = 4;
    localparam int VER_LSB   = 16;
    localparam int NXT_LSB   = 20;
    localparam int ALIGN_W   = 2;
    localparam int MIN_SIZE  = 8;

    localparam logic [OFF_W-1:0] BASE_OFF = 12'h100;
    localparam logic [OFF_W-1:0] LAST_OFF = 12'hFF8;

    typedef enum logic [1:0] {
        OP_FIND   = 2'd0,
        OP_TAIL   = 2'd1,
        OP_APPEND = 2'd2,
        OP_TAIL2  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_EVAL = 3'd2,
        ST_LINK = 3'd3,
        ST_PUT  = 3'd4
    } st_e;

    typedef struct packed {
        st_e                 st;
        logic                app;
        logic                blind;
        logic [ID_W-1:0]     id;
        logic [VER_W-1:0]    ver;
        logic [OFF_W-1:0]    off;
        logic [OFF_W-1:0]    cur;
        logic [OFF_W-1:0]    prv;
        logic [NXT_LSB-1:0]  keep;
        logic [OFF_W-1:0]    res;
        logic [OFF_W-1:0]    prev;
        logic                err;
        logic                done;
    } walk_s;

endpackage

// File: rtl/ecap_hdr_eval.sv
module ecap_hdr_eval
    import ecap_walk_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [OFF_W-1:0] cur_i,
    input  logic [ID_W-1:0]  want_i,
    input  logic             blind_i,
    output logic             empty_o,
    output logic             hit_o,
    output logic             end_o,
    output logic             bad_o,
    output logic [OFF_W-1:0] nxt_o
);

    always_comb begin
        nxt_o   = hdr_i[NXT_LSB +: OFF_W];
        empty_o = (cur_i == BASE_OFF) && (hdr_i == '0);
        hit_o   = !blind_i && (hdr_i[ID_W-1:0] == want_i);
        end_o   = (nxt_o == '0);
        bad_o   = (nxt_o[ALIGN_W-1:0] != '0) || (nxt_o < BASE_OFF) || (nxt_o > LAST_OFF);
    end

endmodule

// File: rtl/ecap_append_vet.sv
module ecap_append_vet
    import ecap_walk_pkg::*;
#(
    parameter int SIZE_W = 13
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              ok_o,
    output logic              base_o
);

    localparam int SUM_W = ((OFF_W > SIZE_W) ? OFF_W : SIZE_W) + 1;
    localparam logic [SUM_W-1:0] SPACE = SUM_W'(1) << OFF_W;

    logic [SUM_W-1:0] span_end;

    always_comb begin
        span_end = SUM_W'(off_i) + SUM_W'(size_i);
        base_o   = (off_i == BASE_OFF);
        ok_o     = (off_i >= BASE_OFF)
                && (off_i[ALIGN_W-1:0] == '0)
                && (span_end <= SPACE)
                && (size_i >= SIZE_W'(MIN_SIZE));
    end

endmodule

// File: rtl/ecap_step_guard.sv
module ecap_step_guard #(
    parameter int LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CW'(LIMIT))) begin
            cnt_d = cnt_q + 1'b1;
        end
        last_o = (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/ecap_chain_walker.sv
module ecap_chain_walker
    import ecap_walk_pkg::*;
#(
    parameter int STEP_LIMIT = 1024,
    parameter int SIZE_W     = 13
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [1:0]         op_i,
    input  logic [ID_W-1:0]    cap_id_i,
    input  logic [VER_W-1:0]   cap_ver_i,
    input  logic [OFF_W-1:0]   offset_i,
    input  logic [SIZE_W-1:0]  size_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic [OFF_W-1:0]   result_o,
    output logic [OFF_W-1:0]   prev_o,
    output logic               mem_rd_en_o,
    output logic               mem_wr_en_o,
    output logic [OFF_W-1:0]   mem_addr_o,
    output logic [HDR_W-1:0]   mem_wdata_o,
    input  logic [HDR_W-1:0]   mem_rdata_i
);

    walk_s d, q;

    op_e              op_in;
    logic             h_empty, h_hit, h_end, h_bad;
    logic [OFF_W-1:0] h_nxt;
    logic             vet_ok, vet_base;
    logic             s_clr, s_inc, s_last;

    assign op_in = op_e'(op_i);

    ecap_hdr_eval u_eval (
        .hdr_i   (mem_rdata_i),
        .cur_i   (q.cur),
        .want_i  (q.id),
        .blind_i (q.blind),
        .empty_o (h_empty),
        .hit_o   (h_hit),
        .end_o   (h_end),
        .bad_o   (h_bad),
        .nxt_o   (h_nxt)
    );

    ecap_append_vet #(.SIZE_W(SIZE_W)) u_vet (
        .off_i  (offset_i),
        .size_i (size_i),
        .ok_o   (vet_ok),
        .base_o (vet_base)
    );

    ecap_step_guard #(.LIMIT(STEP_LIMIT)) u_guard (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (s_clr),
        .inc_i  (s_inc),
        .last_o (s_last)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        mem_rd_en_o = 1'b0;
        mem_wr_en_o = 1'b0;
        mem_addr_o  = q.cur;
        mem_wdata_o = '0;
        s_clr       = 1'b0;
        s_inc       = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.app   = (op_in == OP_APPEND);
                    d.blind = (op_in != OP_FIND);
                    d.id    = cap_id_i;
                    d.ver   = cap_ver_i;
                    d.off   = offset_i;
                    d.cur   = BASE_OFF;
                    d.prv   = '0;
                    d.res   = '0;
                    d.prev  = '0;
                    d.err   = 1'b0;
                    s_clr   = 1'b1;
                    if (op_in == OP_APPEND) begin
                        if (!vet_ok) begin
                            d.err  = 1'b1;
                            d.done = 1'b1;
                        end else if (vet_base) begin
                            d.st = ST_PUT;
                        end else begin
                            d.st = ST_READ;
                        end
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_rd_en_o = 1'b1;
                d.st        = ST_EVAL;
            end
            ST_EVAL: begin
                s_inc = 1'b1;
                if (h_empty) begin
                    d.err  = q.app;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (h_hit) begin
                    d.res  = q.cur;
                    d.prev = q.prv;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else if (h_end) begin
                    if (q.app) begin
                        d.prv  = q.cur;
                        d.keep = mem_rdata_i[NXT_LSB-1:0];
                        d.st   = ST_LINK;
                    end else begin
                        d.prev = q.cur;
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end else if (h_bad || s_last) begin
                    d.err  = 1'b1;
                    d.prev = q.cur;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.prv = q.cur;
                    d.cur = h_nxt;
                    d.st  = ST_READ;
                end
            end
            ST_LINK: begin
                mem_wr_en_o = 1'b1;
                mem_addr_o  = q.prv;
                mem_wdata_o = {q.off, q.keep};
                d.st        = ST_PUT;
            end
            ST_PUT: begin
                mem_wr_en_o                    = 1'b1;
                mem_addr_o                     = q.off;
                mem_wdata_o[ID_W-1:0]          = q.id;
                mem_wdata_o[VER_LSB +: VER_W]  = q.ver;
                d.res                          = q.off;
                d.prev                         = q.prv;
                d.st                           = ST_IDLE;
                d.done                         = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.st != ST_IDLE);
    assign done_o   = q.done;
    assign err_o    = q.err;
    assign result_o = q.res;
    assign prev_o   = q.prev;

    // R4: reads stay aligned and inside the extended region
    a_r4_read_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_rd_en_o |-> (mem_addr_o[ALIGN_W-1:0] == '0 && mem_addr_o >= BASE_OFF && mem_addr_o <= LAST_OFF));

    // R4: the port never reads and writes together
    a_r4_one_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_en_o && mem_wr_en_o));

    // R2: completion pulse follows the end of busy
    a_r2_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    // R8: an error never reports a found offset
    a_r8_err_clears_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && err_o) |-> (result_o == '0));

    // R9: the step guard ends a walk that would continue
    a_r9_limit_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_EVAL && s_last && !h_empty && !h_hit && !h_end) |=> (!busy_o && err_o));

endmodule

// File: tb/ecap_chain_walker_tb_top.sv
`timescale 1ns/1ps
module ecap_chain_walker_tb_top;

    localparam int LIMIT = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [15:0] cid = '0;
    logic [3:0]  cver = '0;
    logic [11:0] coff = '0;
    logic [12:0] csize = '0;
    logic        busy, done, err;
    logic [11:0] result, prev;
    logic        rd_en, wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;

    logic [31:0] mem [1024];
    logic [31:0] ref_mem [1024];
    logic        pk_en = 1'b0;
    logic        wipe = 1'b0;
    logic [9:0]  pk_addr = '0;
    logic [31:0] pk_val = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    ecap_chain_walker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
        .cap_id_i(cid), .cap_ver_i(cver), .offset_i(coff), .size_i(csize),
        .busy_o(busy), .done_o(done), .err_o(err), .result_o(result), .prev_o(prev),
        .mem_rd_en_o(rd_en), .mem_wr_en_o(wr_en), .mem_addr_o(addr),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata)
    );

    always @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < 1024; i++) mem[i] <= '0;
        end else begin
            if (pk_en) mem[pk_addr] <= pk_val;
            if (wr_en) mem[addr[11:2]] <= wdata;
        end
        if (rd_en) rdata <= mem[addr[11:2]];
        if (rd_en) rd_cnt <= rd_cnt + 1;
        if (wr_en) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input int byte_off, input logic [31:0] v);
        ref_mem[byte_off >> 2] = v;
        @(negedge clk);
        pk_en = 1'b1; pk_addr = 10'(byte_off >> 2); pk_val = v;
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    task automatic wipe_all();
        for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
        @(negedge clk); wipe = 1'b1;
        @(negedge clk); wipe = 1'b0;
    endtask

    // behavioural chain walk over the reference image
    function automatic void mdl_walk(input bit blind, input logic [15:0] id,
                                     output int res, output int prv, output bit e, output int nrd);
        int cur; int pv; int nx; logic [31:0] h;
        cur = 256; pv = 0; res = 0; prv = 0; e = 1'b0; nrd = 0;
        while (1) begin
            h = ref_mem[cur >> 2];
            nrd++;
            if (cur == 256 && h == 0) return;
            if (!blind && h[15:0] == id) begin res = cur; prv = pv; return; end
            nx = int'(h[31:20]);
            if (nx == 0) begin prv = cur; return; end
            if ((nx % 4) != 0 || nx < 256 || nx > 4088 || nrd == LIMIT) begin
                e = 1'b1; prv = cur; return;
            end
            pv = cur; cur = nx;
        end
    endfunction

    task automatic run_op(input string tag, input logic [1:0] o, input logic [15:0] id,
                          input logic [3:0] ver, input int off, input int size, input bit poke_busy);
        int eres, eprv, nrd, eb, erd, ewr, r0, w0, bad, mm;
        bit eerr;
        eres = 0; eprv = 0; eerr = 0; nrd = 0; eb = 0; erd = 0; ewr = 0;
        if (o == 2'd2) begin
            if (off < 256 || (off % 4) != 0 || off + size > 4096 || size < 8) begin
                eerr = 1'b1;
            end else if (off == 256) begin
                ref_mem[64] = {12'h0, ver, id};
                eb = 1; ewr = 1; eres = 256;
            end else begin
                mdl_walk(1'b1, id, eres, eprv, eerr, nrd);
                erd = nrd; eb = 2 * nrd;
                if (!eerr && eprv == 0) begin
                    eerr = 1'b1;
                end else if (!eerr) begin
                    ref_mem[eprv >> 2][31:20] = 12'(off);
                    ref_mem[off >> 2] = {12'h0, ver, id};
                    eb = eb + 2; ewr = 2; eres = off;
                end
            end
        end else begin
            mdl_walk(o != 2'd0, id, eres, eprv, eerr, nrd);
            erd = nrd; eb = 2 * nrd;
        end
        r0 = rd_cnt; w0 = wr_cnt; bad = 0;
        @(negedge clk);
        start = 1'b1; op = o; cid = id; cver = ver; coff = 12'(off); csize = 13'(size);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= eb; k++) begin
            if (k > 0) @(negedge clk);
            if (busy !== (k < eb) || done !== (k == eb)) bad++;
            if (poke_busy && k == 1) begin
                start = 1'b1; op = 2'd0; cid = 16'hFFFF;
            end else begin
                start = 1'b0;
            end
        end
        chk(bad == 0, tag, "busy/done trace (R2)", bad, 0);
        chk(result == 12'(eres), tag, "result", int'(result), eres);
        chk(prev == 12'(eprv), tag, "prev", int'(prev), eprv);
        chk(err == eerr, tag, "err", int'(err), int'(eerr));
        chk(rd_cnt - r0 == erd, tag, "reads", rd_cnt - r0, erd);
        chk(wr_cnt - w0 == ewr, tag, "writes", wr_cnt - w0, ewr);
        mm = 0;
        for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) mm++;
        chk(mm == 0, tag, "memory image words differing", mm, 0);
        @(negedge clk);
        chk(done == 1'b0, tag, "done single pulse (R2)", int'(done), 0);
        chk(result == 12'(eres) && err == eerr, tag, "results held (R2)", int'(result), eres);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) ref_mem[i] = '0;
        wipe = 1'b1;
        repeat (3) @(negedge clk);
        wipe = 1'b0;
        // R1: reset state
        chk(busy == 0 && done == 0 && err == 0, "R1", "status flags", int'({busy, done, err}), 0);
        chk(result == 0 && prev == 0, "R1", "result/prev", int'(result), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_cnt == 0 && wr_cnt == 0, "R1", "idle memory accesses", rd_cnt + wr_cnt, 0);

        run_op("R3", 2'd0, 16'h0001, 4'h0, 0, 0, 1'b0);
        run_op("R3", 2'd1, 16'h0001, 4'h0, 0, 0, 1'b0);
        run_op("R12", 2'd2, 16'h0003, 4'h1, 320, 16, 1'b0);   // non-base onto empty chain
        run_op("R10", 2'd2, 16'h0001, 4'h2, 256, 64, 1'b0);
        run_op("R11", 2'd2, 16'h0003, 4'h1, 320, 16, 1'b0);
        run_op("R11", 2'd2, 16'h000B, 4'hF, 512, 8, 1'b0);
        run_op("R5", 2'd0, 16'h0003, 4'h0, 0, 0, 1'b0);
        run_op("R5", 2'd0, 16'h0001, 4'h0, 0, 0, 1'b0);
        run_op("R5", 2'd0, 16'h000B, 4'h0, 0, 0, 1'b1);      // start while busy ignored (R2)
        run_op("R6", 2'd0, 16'h0099, 4'h0, 0, 0, 1'b0);
        run_op("R7", 2'd1, 16'h0001, 4'h0, 0, 0, 1'b0);
        run_op("R7", 2'd3, 16'h0003, 4'h0, 0, 0, 1'b0);
        run_op("R4", 2'd0, 16'h0002, 4'h0, 0, 0, 1'b0);      // id 0x0002 vs ver bits in 19:16
        // R12: argument checks
        run_op("R12", 2'd2, 16'h0007, 4'h1, 128, 16, 1'b0);
        run_op("R12", 2'd2, 16'h0007, 4'h1, 578, 16, 1'b0);
        run_op("R12", 2'd2, 16'h0007, 4'h1, 4088, 16, 1'b0);
        run_op("R12", 2'd2, 16'h0007, 4'h1, 1024, 4, 1'b0);
        run_op("R11", 2'd2, 16'h0007, 4'h1, 4088, 8, 1'b0);  // exactly fills space
        // R8: malformed links
        poke(4088, {12'h102, 4'h1, 16'h0007});
        run_op("R8", 2'd0, 16'h0055, 4'h0, 0, 0, 1'b0);
        poke(4088, {12'h0F0, 4'h1, 16'h0007});
        run_op("R8", 2'd1, 16'h0055, 4'h0, 0, 0, 1'b0);
        poke(4088, {12'hFFC, 4'h1, 16'h0007});
        run_op("R8", 2'd0, 16'h0055, 4'h0, 0, 0, 1'b0);
        // R9: self-referencing chain
        wipe_all();
        poke(256, {12'h100, 4'h1, 16'h0005});
        run_op("R9", 2'd0, 16'h0077, 4'h0, 0, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule